// File: doc/BRIEF.md
# Console Serial Port Register Front End

This block is the byte-wide register face of a simple serial console. A memory-mapped bus on one side issues single-cycle reads and writes by offset. On the other side sit two character streams: an incoming stream with valid, data and a ready back-pressure signal, and an outgoing stream with valid and data. The block holds at most one received character at a time. It keeps a pending flag for the transmit interrupt and reports both interrupt conditions through a status byte. It also has a sticky error flag that marks accesses a console driver should never make.

A small pointer state machine sits behind the command offset. It has two states. `PTR_LINE` is the default, and in it a status read returns line status. `PTR_SRC` is entered by writing the arm code `0x03` to the command offset, and in it the next status read returns an interrupt-source code. The transitions are *arm* (a command write of `0x03`, from either state to `PTR_SRC`), *disarm* (a command write of any other value, to `PTR_LINE`) and *consume* (a status read while in `PTR_SRC`, back to `PTR_LINE`). The holding slot is a second machine with states `HOLD_EMPTY` and `HOLD_FULL`. Its transitions are *capture* (incoming valid while empty) and *drain* (a data read while full).

Offsets for baud divisors, interrupt enables and modem control decode, but writes to them do nothing and reads of them return zero. The serial shifting itself lives elsewhere.

Top module: `cons_uart_regs`

## Requirements
- R1: In `PTR_LINE`, a read of offset 0xD (status) returns 0x64, with bit 0 also set (0x65) when a character is held, or when one is offered on the incoming stream in that same cycle while the slot is empty.
- R2: Every write to offset 0xB (command) updates the pointer: the value 0x03 selects `PTR_SRC`, and any other value selects `PTR_LINE`.
- R3: In `PTR_SRC`, a status read returns 0x10 if a transmit interrupt is pending. Otherwise it returns 0x20 if a character is held or offered, and otherwise 0x00. The pointer is back in `PTR_LINE` for the following access.
- R4: Writing 0x28 to the command offset clears a pending transmit interrupt. Writing 0x28 when none is pending sets the error flag.
- R5: A read of offset 0x8 (data) while a character is held returns that character and empties the slot.
- R6: A data read while the slot is empty returns 0x00 and sets the error flag.
- R7: A write of offset 0x8 drives `tx_valid` high with `tx_data` equal to the written byte in that same cycle. A transmit interrupt is pending from the next cycle onward.
- R8: Reads of 0x9, 0xC and any unmapped offset return 0x00. Writes to 0x9, 0xC or unmapped offsets change no output and no state: the pointer, the pending flag, the slot and the error flag are all unaffected.
- R9: `rx_ready` is high exactly while the slot is empty. A character is captured on a clock edge where `rx_valid` and `rx_ready` are both high.
- R10: After reset, `rx_ready` is 1, `err_flag` is 0, no transmit interrupt is pending and the pointer is in `PTR_LINE`.
- R11: Once set, the error flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid in the cycle of the read |
| rx_valid | input | 1 | Incoming character offered |
| rx_data | input | 8 | Incoming character |
| rx_ready | output | 1 | Slot empty, character can be taken |
| tx_valid | output | 1 | Outgoing character strobe |
| tx_data | output | 8 | Outgoing character |
| err_flag | output | 1 | Sticky misuse flag |

## Verification
The bench builds the block with `ADDR_W = 6`. This makes offsets above 0xF reachable, so a read or write at 0x1D checks that status is fully decoded and not aliased on its low nibble. All remaining parameters are fixed at byte width. A reset between phases lets the sticky error flag be attributed to a single cause: either an unmatched acknowledge or an empty data read.

// File: rtl/cons_uart_pkg.sv
package cons_uart_pkg;
    localparam int BYTE_W = 8;

    localparam logic [3:0] OFS_DATA = 4'h8;
    localparam logic [3:0] OFS_IER  = 4'h9;
    localparam logic [3:0] OFS_CMD  = 4'hB;
    localparam logic [3:0] OFS_MCR  = 4'hC;
    localparam logic [3:0] OFS_STAT = 4'hD;

    localparam logic [BYTE_W-1:0] CMD_ARM   = 8'h03;
    localparam logic [BYTE_W-1:0] CMD_TXACK = 8'h28;
    localparam logic [BYTE_W-1:0] LINE_BASE = 8'h64;
    localparam logic [BYTE_W-1:0] SRC_TX    = 8'h10;
    localparam logic [BYTE_W-1:0] SRC_RX    = 8'h20;

    typedef enum logic { PTR_LINE, PTR_SRC } ptr_state_t;
    typedef enum logic { HOLD_EMPTY, HOLD_FULL } hold_state_t;
endpackage

// File: rtl/cons_ptr_fsm.sv
module cons_ptr_fsm
    import cons_uart_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [BYTE_W-1:0] cmd_byte,
    input  logic              stat_rd,
    output ptr_state_t        state
);
    ptr_state_t state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PTR_LINE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (cmd_wr) begin
            state_nx = (cmd_byte == CMD_ARM) ? PTR_SRC : PTR_LINE;   // arm / disarm
        end else begin
            unique case (state)
                PTR_LINE: state_nx = PTR_LINE;
                PTR_SRC:  if (stat_rd) state_nx = PTR_LINE;          // consume
                default:  state_nx = PTR_LINE;
            endcase
        end
    end

    // R3: a source read hands the pointer back to line status
    p_src_consume_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !cmd_wr && state == PTR_SRC) |=> (state == PTR_LINE));
    // R2: arm code always lands in PTR_SRC
    p_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_byte == CMD_ARM) |=> (state == PTR_SRC));
endmodule

// File: rtl/cons_rx_hold.sv
module cons_rx_hold
    import cons_uart_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              take,
    output logic              rx_ready,
    output logic              full,
    output logic [BYTE_W-1:0] held
);
    hold_state_t state, state_nx;
    logic        capture;

    assign capture = rx_valid && (state == HOLD_EMPTY);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= HOLD_EMPTY;
            held  <= '0;
        end else begin
            state <= state_nx;
            if (capture) held <= rx_data;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            HOLD_EMPTY: if (rx_valid) state_nx = HOLD_FULL;     // capture
            HOLD_FULL:  if (take)     state_nx = HOLD_EMPTY;    // drain
            default:    state_nx = HOLD_EMPTY;
        endcase
    end

    always_comb begin
        rx_ready = (state == HOLD_EMPTY);
        full     = (state == HOLD_FULL);
    end

    // R9: an accepted character is what the slot then holds
    p_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready) |=> (full && held == $past(rx_data)));
    // R5: a data read of a full slot empties it
    p_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && full) |=> rx_ready);
endmodule

// File: rtl/cons_tx_flag.sv
module cons_tx_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic xmit,
    input  logic ack,
    output logic pend,
    output logic ack_miss
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    pend <= 1'b0;
        else if (xmit) pend <= 1'b1;
        else if (ack)  pend <= 1'b0;
    end

    assign ack_miss = ack && !pend;

    // R7: each sent byte leaves an interrupt pending
    p_tx_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
        xmit |=> pend);
    // R4: acknowledge clears it
    p_ack_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !xmit) |=> !pend);
endmodule

// File: rtl/cons_uart_regs.sv
module cons_uart_regs
    import cons_uart_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              err_flag
);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFS_CMD);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

    logic        rd, wr;
    logic        data_rd, data_wr, cmd_wr, stat_rd, tx_ack;
    logic        full, pend, ack_miss, rx_seen;
    logic [7:0]  held;
    ptr_state_t  ptr;

    always_comb begin
        rd      = bus_sel && !bus_we;
        wr      = bus_sel && bus_we;
        data_rd = rd && (bus_addr == A_DATA);
        data_wr = wr && (bus_addr == A_DATA);
        cmd_wr  = wr && (bus_addr == A_CMD);
        stat_rd = rd && (bus_addr == A_STAT);
        tx_ack  = cmd_wr && (bus_wdata == CMD_TXACK);
    end

    cons_ptr_fsm u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (cmd_wr),
        .cmd_byte (bus_wdata),
        .stat_rd  (stat_rd),
        .state    (ptr)
    );

    cons_rx_hold u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .take     (data_rd),
        .rx_ready (rx_ready),
        .full     (full),
        .held     (held)
    );

    cons_tx_flag u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .xmit     (data_wr),
        .ack      (tx_ack),
        .pend     (pend),
        .ack_miss (ack_miss)
    );

    assign tx_valid = data_wr;
    assign tx_data  = bus_wdata;

    // a status read on an empty slot sees a character offered in the same cycle
    assign rx_seen = full || rx_valid;

    always_comb begin
        bus_rdata = '0;
        if (data_rd && full) begin
            bus_rdata = held;
        end else if (stat_rd) begin
            unique case (ptr)
                PTR_LINE: bus_rdata = LINE_BASE | {7'd0, rx_seen};
                PTR_SRC:  bus_rdata = pend    ? SRC_TX :
                                      rx_seen ? SRC_RX : 8'h00;
                default:  bus_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 err_flag <= 1'b0;
        else if (ack_miss || (data_rd && !full))    err_flag <= 1'b1;
    end

    // R1: line status always carries bits 6, 5 and 2
    p_line_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && ptr == PTR_LINE) |-> (bus_rdata[6:5] == 2'b11 && bus_rdata[2]));
    // R11: error flag is sticky
    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);
    // R6: empty data read raises the flag
    p_empty_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !full) |=> err_flag);
endmodule

// File: tb/cons_uart_regs_bench.sv
`timescale 1ns/100ps
module cons_uart_regs_bench;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0, bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_data = '0;
    logic          rx_ready, tx_valid, err_flag;
    logic [7:0]    tx_data;

    int nchk = 0, nfail = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    cons_uart_regs #(.ADDR_W(AW)) u_cons_uart_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .err_flag(err_flag)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    // monitor: compares every read against the scoreboard
    always @(negedge clk) begin
        if (bus_sel && !bus_we) begin
            if (exp_q.size() == 0) chk("scoreboard underflow", 8'h01, 8'h00);
            else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
    end

    task automatic bus_rd(input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
        @(posedge clk); #0.5;
        exp_q.push_back(exp); tag_q.push_back(tag);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(posedge clk); #0.5;
        bus_sel = 1'b0;
    endtask

    task automatic bus_wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(posedge clk); #0.5;
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #0.5;
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rx_push(input logic [7:0] d);
        @(posedge clk); #0.5;
        rx_valid = 1'b1; rx_data = d;
        @(posedge clk); #0.5;
        rx_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(posedge clk); #0.5;
        rst_n = 1'b0;
        @(posedge clk); #0.5;
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin : stim
        repeat (2) @(posedge clk); #0.5;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 rx_ready", {7'd0, rx_ready}, 8'h01);
        chk("R10 err_flag", {7'd0, err_flag}, 8'h00);
        chk("R10 tx_valid", {7'd0, tx_valid}, 8'h00);
        bus_rd(6'h0D, 8'h64, "R1 R10 line status idle");

        // pointer arm with nothing pending
        bus_wr(6'h0B, 8'h03);
        bus_rd(6'h0D, 8'h00, "R3 source read none");
        bus_rd(6'h0D, 8'h64, "R3 pointer cleared");

        // arm then disarm
        bus_wr(6'h0B, 8'h03);
        bus_wr(6'h0B, 8'h12);
        bus_rd(6'h0D, 8'h64, "R2 other value disarms");

        // transmit
        @(posedge clk); #0.5;
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 6'h08; bus_wdata = 8'h41;
        @(negedge clk);
        chk("R7 tx_valid", {7'd0, tx_valid}, 8'h01);
        chk("R7 tx_data", tx_data, 8'h41);
        @(posedge clk); #0.5;
        bus_sel = 1'b0; bus_we = 1'b0;
        @(negedge clk);
        chk("R7 tx_valid drops", {7'd0, tx_valid}, 8'h00);
        bus_wr(6'h0B, 8'h03);
        bus_rd(6'h0D, 8'h10, "R3 R7 source tx pending");

        // writes to non-command offsets leave pending and pointer alone
        bus_wr(6'h0C, 8'h28);
        bus_wr(6'h09, 8'h28);
        bus_wr(6'h1D, 8'h28);
        bus_wr(6'h09, 8'h03);
        bus_rd(6'h0D, 8'h64, "R8 write to 0x09 does not arm");
        bus_wr(6'h0B, 8'h03);
        bus_rd(6'h0D, 8'h10, "R8 pending survives ignored writes");
        chk("R8 err unaffected", {7'd0, err_flag}, 8'h00);

        // rx held with tx pending: tx has priority
        rx_push(8'h5A);
        @(negedge clk);
        chk("R9 ready low when full", {7'd0, rx_ready}, 8'h00);
        bus_rd(6'h0D, 8'h65, "R1 held char bit0");
        bus_wr(6'h0B, 8'h03);
        bus_rd(6'h0D, 8'h10, "R3 tx over rx priority");

        // acknowledge tx
        bus_wr(6'h0B, 8'h28);
        bus_wr(6'h0B, 8'h03);
        bus_rd(6'h0D, 8'h20, "R3 R4 source rx after ack");
        chk("R4 err after good ack", {7'd0, err_flag}, 8'h00);

        // R9: offered char is not taken while full
        rx_push(8'hC3);
        bus_rd(6'h08, 8'h5A, "R5 R9 data read returns first char");
        @(negedge clk);
        chk("R5 ready back high", {7'd0, rx_ready}, 8'h01);
        bus_rd(6'h0D, 8'h64, "R5 slot empty after read");

        // status read pulls in an offered char
        @(posedge clk); #0.5;
        rx_valid = 1'b1; rx_data = 8'h33;
        exp_q.push_back(8'h65); tag_q.push_back("R1 status sees offered char");
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 6'h0D;
        @(posedge clk); #0.5;
        bus_sel = 1'b0; rx_valid = 1'b0;
        bus_rd(6'h08, 8'h33, "R5 R9 captured char");

        // zero reads
        bus_rd(6'h09, 8'h00, "R8 read 0x09");
        bus_rd(6'h0C, 8'h00, "R8 read 0x0C");
        bus_rd(6'h1D, 8'h00, "R8 read unmapped 0x1D");
        bus_rd(6'h0B, 8'h00, "R8 read command offset");
        chk("R8 err still clear", {7'd0, err_flag}, 8'h00);

        // unmatched ack
        bus_wr(6'h0B, 8'h28);
        @(negedge clk);
        chk("R4 ack miss sets err", {7'd0, err_flag}, 8'h01);
        bus_rd(6'h0D, 8'h64, "R11 status read");
        @(negedge clk);
        chk("R11 err sticky", {7'd0, err_flag}, 8'h01);

        // empty data read
        do_reset();
        @(negedge clk);
        chk("R10 err cleared by reset", {7'd0, err_flag}, 8'h00);
        bus_rd(6'h08, 8'h00, "R6 empty data read value");
        @(negedge clk);
        chk("R6 empty read sets err", {7'd0, err_flag}, 8'h01);

        repeat (2) @(posedge clk);
        if (exp_q.size() != 0) chk("scoreboard drained", 8'(exp_q.size()), 8'h00);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule